// File: doc/BRIEF.md
# Slot-Aware Next-Bundle Predictor

This block sits in the fetch stage of a processor whose instruction bundles carry several issue slots, any of which may hold a branch. In every cycle it receives the index of the bundle being fetched. From that index alone it produces a taken or not-taken guess, the issue slot expected to hold the taken branch, and the index of the next bundle to fetch. The direction comes from a table of two-bit saturating counters. That table is indexed by the bundle index folded with a global record of recent branch outcomes.

When the guess is taken, the stored slot number is joined to the bundle index to form the key into a direct-mapped target store. A valid entry whose tag matches gives the next bundle index. On any miss, and on any not-taken guess, fetch continues with the following bundle.

Branches are resolved later in the pipeline and reported on a single update port. The update trains the counter table, records the slot, fills the target store and advances the outcome history. Nothing is trained speculatively at fetch time. The lookup is combinational from registered tables, so the answer is ready in the cycle the index is presented.

Top module: `slot_branch_predictor`

## Requirements
- R1: After reset every counter holds weakly not-taken (value 1), every slot field holds 0, every target entry is invalid and the history is all zeros. A lookup then gives pred_taken=0, pred_slot=0, btb_hit=0 and next_pc=lk_addr+1.
- R2: The counter used for a lookup or an update is the entry at index (address bits [10:0]) XOR (history [10:0]). The history used is its current value, before any shift by an update in the same cycle.
- R3: A counter moves up by one on a taken update and down by one on a not-taken update. It saturates at 3 and at 0, and pred_taken is its upper bit (values 2 and 3 mean taken).
- R4: pred_slot equals the slot field of the selected entry when pred_taken=1 and is 0 otherwise. A taken update writes upd_slot into the slot field. A not-taken update leaves the slot field unchanged.
- R5: The target store is indexed by {address[6:0], slot} (9 bits, slot in the low 2 bits) and tagged with address[31:7]. btb_hit=1 only when pred_taken=1 and the entry at {lk_addr[6:0], pred_slot} is valid with a matching tag.
- R6: next_pc equals the stored target when btb_hit=1. Otherwise it is lk_addr+1, wrapping modulo 2^32.
- R7: A taken update makes the entry at {upd_addr[6:0], upd_slot} valid, with tag upd_addr[31:7] and target upd_target. A not-taken update writes no target entry.
- R8: A lookup in the same cycle as an update to the same entries sees the contents from before that update.
- R9: Each update shifts the history left by one and places upd_taken in bit 0. Without an update the history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Index of the bundle being fetched |
| upd_en | input | 1 | A resolved branch is being reported this cycle |
| upd_addr | input | 32 | Bundle index of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_slot | input | 2 | Issue slot of the resolved taken branch |
| upd_target | input | 32 | Resolved target bundle index |
| pred_taken | output | 1 | Predicted direction for lk_addr |
| pred_slot | output | 2 | Predicted slot of the taken branch |
| btb_hit | output | 1 | Taken guess found a matching target entry |
| next_pc | output | 32 | Predicted next bundle index |

## Verification
The assertions assume that reset is high from time zero and that every input holds a known value once reset is released. They also assume that the update fields are meaningful whenever upd_en is high, and that a report arrives in the same order as the lookup it corrects, so that the history at update time matches the history seen at fetch. The stimulus changes every input only at falling edges and holds reset for several cycles at the start. It reports resolves in order, one per cycle at most, which keeps the history seen at fetch and at resolve in step. Addresses are drawn from a narrow window so that entries are trained and re-read often.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CNT_STRONG_NT = 2'd0,
    CNT_WEAK_NT   = 2'd1,
    CNT_WEAK_T    = 2'd2,
    CNT_STRONG_T  = 2'd3
  } cnt_t;

  // saturating step of a direction counter
  function automatic cnt_t cnt_step(input cnt_t cur, input logic taken);
    cnt_t nxt;
    nxt = cur;
    if (taken && cur != CNT_STRONG_T)
      nxt = cnt_t'(cur + 2'd1);
    else if (!taken && cur != CNT_STRONG_NT)
      nxt = cnt_t'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic          upd_taken,
  output logic [HW-1:0] hist
);

  logic [HW-1:0] hist_q;

  generate
    if (HW > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)
          hist_q <= '0;
        else if (upd_en)
          hist_q <= {hist_q[HW-2:0], upd_taken};
      end
    end else begin : g_one
      always_ff @(posedge clk) begin
        if (rst)
          hist_q <= '0;
        else if (upd_en)
          hist_q <= upd_taken;
      end
    end
  endgenerate

  assign hist = hist_q;

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int ENTRIES = 2048,
  parameter int SW      = 2,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_taken,
  output logic [SW-1:0] rd_slot,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_taken,
  input  logic [SW-1:0] wr_slot
);

  cnt_t          cnt_q  [ENTRIES];
  logic [SW-1:0] slot_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cnt_q[i]  <= CNT_WEAK_NT;
        slot_q[i] <= '0;
      end
    end else if (wr_en) begin
      cnt_q[wr_idx] <= cnt_step(cnt_q[wr_idx], wr_taken);
      if (wr_taken)
        slot_q[wr_idx] <= wr_slot;
    end
  end

  // old contents are seen on a same-cycle read
  cnt_t rd_cnt;
  assign rd_cnt   = cnt_q[rd_idx];
  assign rd_taken = rd_cnt[1];
  assign rd_slot  = slot_q[rd_idx];

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int ENTRIES = 512,
  parameter int TW      = 25,
  parameter int AW      = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  input  logic [TW-1:0] rd_tag,
  output logic          rd_hit,
  output logic [AW-1:0] rd_target,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic [AW-1:0] wr_target
);

  logic [ENTRIES-1:0] valid_q;
  logic [TW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];

  // only the valid bits are reset; tags and targets stay plain memory
  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (wr_en)
      valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
    end
  end

  assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_target = tgt_q[rd_idx];

endmodule

// File: rtl/slot_branch_predictor.sv
module slot_branch_predictor #(
  parameter int AW          = 32,
  parameter int PHT_ENTRIES = 2048,
  parameter int BTB_ENTRIES = 512,
  parameter int SLOTS       = 4,
  localparam int PHT_IW     = $clog2(PHT_ENTRIES),
  localparam int BTB_IW     = $clog2(BTB_ENTRIES),
  localparam int SW         = $clog2(SLOTS),
  localparam int LOW_W      = BTB_IW - SW,
  localparam int TAG_W      = AW - LOW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_addr,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic          upd_taken,
  input  logic [SW-1:0] upd_slot,
  input  logic [AW-1:0] upd_target,
  output logic          pred_taken,
  output logic [SW-1:0] pred_slot,
  output logic          btb_hit,
  output logic [AW-1:0] next_pc
);

  logic [PHT_IW-1:0] ghr_q;

  bp_ghr #(.HW(PHT_IW)) u_ghr (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .upd_taken (upd_taken),
    .hist      (ghr_q)
  );

  // gshare folding of address and history
  logic [PHT_IW-1:0] lk_idx, up_idx;
  assign lk_idx = lk_addr[PHT_IW-1:0] ^ ghr_q;
  assign up_idx = upd_addr[PHT_IW-1:0] ^ ghr_q;

  logic          dir_taken;
  logic [SW-1:0] dir_slot;

  bp_pht #(.ENTRIES(PHT_ENTRIES), .SW(SW)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_idx),
    .rd_taken (dir_taken),
    .rd_slot  (dir_slot),
    .wr_en    (upd_en),
    .wr_idx   (up_idx),
    .wr_taken (upd_taken),
    .wr_slot  (upd_slot)
  );

  // target key: low bundle bits joined with the predicted slot
  logic [SW-1:0]     slot_sel;
  logic [BTB_IW-1:0] lk_key, up_key;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  assign slot_sel = dir_taken ? dir_slot : '0;
  assign lk_key   = {lk_addr[LOW_W-1:0], slot_sel};
  assign lk_tag   = lk_addr[AW-1:LOW_W];
  assign up_key   = {upd_addr[LOW_W-1:0], upd_slot};
  assign up_tag   = upd_addr[AW-1:LOW_W];

  logic          tgt_hit;
  logic [AW-1:0] tgt_val;

  bp_btb #(.ENTRIES(BTB_ENTRIES), .TW(TAG_W), .AW(AW)) u_btb (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (lk_key),
    .rd_tag    (lk_tag),
    .rd_hit    (tgt_hit),
    .rd_target (tgt_val),
    .wr_en     (upd_en && upd_taken),
    .wr_idx    (up_key),
    .wr_tag    (up_tag),
    .wr_target (upd_target)
  );

  logic use_tgt;
  assign use_tgt    = dir_taken && tgt_hit;
  assign pred_taken = dir_taken;
  assign pred_slot  = slot_sel;
  assign btb_hit    = use_tgt;
  assign next_pc    = use_tgt ? tgt_val : lk_addr + AW'(1);

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int AW = 32,
  parameter int SW = 2,
  parameter int HW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] lk_addr,
  input logic          upd_en,
  input logic          upd_taken,
  input logic          pred_taken,
  input logic [SW-1:0] pred_slot,
  input logic          btb_hit,
  input logic [AW-1:0] next_pc,
  input logic [HW-1:0] ghr
);

  // R1: first cycle after reset sees untrained tables
  a_r1_clean_start: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_taken && !btb_hit));

  // R4: no slot is reported without a taken guess
  a_r4_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> pred_slot == '0);

  // R5: a target hit needs a taken guess
  a_r5_hit_needs_taken: assert property (@(posedge clk) disable iff (rst)
    btb_hit |-> pred_taken);

  // R6: without a hit, fetch is sequential
  a_r6_sequential: assert property (@(posedge clk) disable iff (rst)
    !btb_hit |-> next_pc == lk_addr + AW'(1));

  // R9: history takes the resolved outcome
  a_r9_shift_in: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ghr[0] == $past(upd_taken));

  // R9: history idle without an update
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(ghr));

endmodule

bind slot_branch_predictor bp_checker #(.AW(AW), .SW(SW), .HW(PHT_IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_addr    (lk_addr),
  .upd_en     (upd_en),
  .upd_taken  (upd_taken),
  .pred_taken (pred_taken),
  .pred_slot  (pred_slot),
  .btb_hit    (btb_hit),
  .next_pc    (next_pc),
  .ghr        (ghr_q)
);

// File: tb/tb_slot_branch_predictor.sv
module tb_slot_branch_predictor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic        upd_en = 1'b0;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;
  logic [1:0]  upd_slot = '0;
  logic [31:0] upd_target = '0;
  logic        pred_taken;
  logic [1:0]  pred_slot;
  logic        btb_hit;
  logic [31:0] next_pc;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_branch_predictor dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .upd_en(upd_en),
    .upd_addr(upd_addr), .upd_taken(upd_taken), .upd_slot(upd_slot),
    .upd_target(upd_target), .pred_taken(pred_taken), .pred_slot(pred_slot),
    .btb_hit(btb_hit), .next_pc(next_pc)
  );

  // behavioural reference state
  int          m_cnt [2048];
  int          m_slt [2048];
  bit          m_vld [512];
  logic [31:0] m_tag [512];
  logic [31:0] m_tgt [512];
  int          m_hist;

  task automatic model_reset();
    for (int i = 0; i < 2048; i++) begin m_cnt[i] = 1; m_slt[i] = 0; end
    for (int i = 0; i < 512; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    m_hist = 0;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, then advance the model
  task automatic step(string tag, logic [31:0] la, bit en, logic [31:0] ua,
                      bit tk, int sl, logic [31:0] tg);
    int idx, bi, slot_e;
    bit dir, hit;
    logic [31:0] nxt;
    @(negedge clk);
    lk_addr = la; upd_en = en; upd_addr = ua; upd_taken = tk;
    upd_slot = 2'(sl); upd_target = tg;
    #1;
    idx    = int'(la & 32'h7FF) ^ m_hist;
    dir    = (m_cnt[idx] >= 2);
    slot_e = dir ? m_slt[idx] : 0;
    bi     = (int'(la & 32'h7F) << 2) | slot_e;
    hit    = dir && m_vld[bi] && (m_tag[bi] == (la >> 7));
    nxt    = hit ? m_tgt[bi] : la + 32'd1;
    check(tag, "R3 pred_taken", 32'(pred_taken), 32'(dir));
    check(tag, "R4 pred_slot", 32'(pred_slot), 32'(slot_e));
    check(tag, "R5 btb_hit", 32'(btb_hit), 32'(hit));
    check(tag, "R6 next_pc", next_pc, nxt);
    if (en) begin
      int ui, ub;
      ui = int'(ua & 32'h7FF) ^ m_hist;
      if (tk) begin
        if (m_cnt[ui] < 3) m_cnt[ui]++;
        m_slt[ui] = sl;
        ub = (int'(ua & 32'h7F) << 2) | sl;
        m_vld[ub] = 1; m_tag[ub] = ua >> 7; m_tgt[ub] = tg;
      end else if (m_cnt[ui] > 0) begin
        m_cnt[ui]--;
      end
      m_hist = ((m_hist << 1) | int'(tk)) & 32'h7FF;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: untrained lookups, including address wrap
    step("R1", 32'h0000_0005, 0, 0, 0, 0, 0);
    step("R1", 32'h1234_5678, 0, 0, 0, 0, 0);
    step("R1", 32'hFFFF_FFFF, 0, 0, 0, 0, 0);

    // R3: drive history to all ones, then saturate high
    for (int i = 0; i < 16; i++)
      step("R3", 32'h0000_0040, 1, 32'h0000_0040, 1, 2, 32'h0000_1234);
    // R3: drive history to all zeros, then saturate low
    for (int i = 0; i < 16; i++)
      step("R3", 32'h0000_0040, 1, 32'h0000_0040, 0, 0, 0);
    for (int i = 0; i < 3; i++)
      step("R3", 32'h0000_0040, 0, 0, 0, 0, 0);

    // R7: train targets for several slots, a not-taken report must not overwrite
    for (int s = 0; s < 4; s++)
      step("R7", 32'h0000_0100 + 32'(s), 1, 32'h0000_0200 + 32'(s),
           1, s, 32'h00AB_0000 + 32'(s));
    step("R7", 32'h0000_0200, 1, 32'h0000_0200, 0, 1, 32'hDEAD_BEEF);
    for (int s = 0; s < 4; s++)
      step("R7", 32'h0000_0200 + 32'(s), 0, 0, 0, 0, 0);

    // R8: lookup and update of the same bundle in one cycle
    for (int i = 0; i < 12; i++)
      step("R8", 32'h0000_0333, 1, 32'h0000_0333, 1, 3, 32'h0055_0000 + 32'(i));

    // R5: tag mismatch, same low bits, different high bits
    for (int i = 0; i < 12; i++)
      step("R5", 32'h0001_0333, 1, 32'h0000_0333, 1, 3, 32'h0066_0000);
    step("R5", 32'h0001_0333, 0, 0, 0, 0, 0);

    // R2 R9: mixed random traffic in a narrow window
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] la, ua;
      la = 32'h0000_0300 + 32'($urandom_range(0, 15));
      ua = 32'h0000_0300 + 32'($urandom_range(0, 15));
      step("R2_R9", la, bit'($urandom_range(0, 1)), ua,
           bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
           32'($urandom));
    end

    // R4: slot field kept across not-taken reports
    for (int i = 0; i < 20; i++)
      step("R4", 32'h0000_0777, 1, 32'h0000_0777, (i % 3) != 2, 1, 32'h0000_9000);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1; upd_en = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    step("R1", 32'h0000_0333, 0, 0, 0, 0, 0);
    step("R1", 32'h0000_0040, 0, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule